// File: doc/BRIEF.md
# Vector Coprocessor Control Register File

This block holds the control state that a 32-element vector coprocessor keeps beside its datapaths: the vector length, a per-element comparison result word, and two sticky per-element exception words, one for signed add/subtract overflow and one for fixed-point saturation. It also answers reads of a fixed identification word and of a shadow of the system cycle counter. Software reaches all of these through one register-number port. An access to a register number that the block does not implement is flagged at once, so the issuing logic can raise an illegal-instruction exception.

When a vector instruction issues, the block snapshots the length register. It reports the snapshot and whether it exceeds the 32-element maximum. The snapshot is held until the next issue, so later software writes to the length register cannot disturb an instruction already in flight. The arithmetic units report per-instruction outcomes as a 32-bit element mask with a kind tag. The block folds the mask into the matching flag word, and only elements below the snapshot length take part.

Top module: `vec_ctrl_regs`

## Requirements
- R1: After reset the length, condition, overflow and saturation registers read 0, and `act_len` and `act_err` are 0.
- R2: Register numbers 0, 1, 2, 4, 8 and 12 are implemented. Any other number with `cr_rd_en` or `cr_wr_en` high drives `cr_illegal` high in the same cycle. The read data is then 0, and the write changes no register.
- R3: Register 0 reads as {16'h0000, IMP_NUM[7:0], REV_NUM[7:0]}. Writes to it are ignored.
- R4: Register 1 returns `cnt_in` combinationally. Writes to it are ignored.
- R5: A write to register 2 stores bits 7..0 of `cr_wdata` as the length. A read returns that length zero-extended.
- R6: On a clock edge with `issue_valid` high, `act_len` takes the length held before that edge, so a write in the same cycle does not reach it. `act_err` is set exactly when that value is greater than 32. Both hold until the next issue.
- R7: `upd_kind` 0 (compare): condition bit x takes `upd_mask[x]` for every x < `act_len`. Bits at or above `act_len` are unchanged.
- R8: `upd_kind` 1 (signed overflow): overflow bit x is ORed with `upd_mask[x]` for x < `act_len`. A hardware update never clears a bit.
- R9: `upd_kind` 2 (saturation): saturation bit x is ORed with `upd_mask[x]` for x < `act_len`. A hardware update never clears a bit.
- R10: `upd_kind` 3 changes no register. With `act_len` 0, no update of any kind changes any bit.
- R11: A software write to register 4, 8 or 12 replaces all 32 bits, including clearing sticky bits. When it meets a hardware update of the same register in the same cycle, the software value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_in | input | 32 | System cycle counter value to shadow |
| cr_rd_en | input | 1 | Control register read strobe |
| cr_wr_en | input | 1 | Control register write strobe |
| cr_addr | input | 5 | Control register number |
| cr_wdata | input | 32 | Write data |
| cr_rdata | output | 32 | Read data (combinational) |
| cr_illegal | output | 1 | Access to an unimplemented register number |
| issue_valid | input | 1 | A vector instruction issues this cycle |
| act_len | output | 8 | Length captured at the last issue |
| act_err | output | 1 | Captured length exceeds 32 |
| upd_valid | input | 1 | Flag update from an arithmetic unit |
| upd_kind | input | 2 | 0 compare, 1 overflow, 2 saturation, 3 none |
| upd_mask | input | 32 | Per-element result bits |

## Verification
The bench drives a length write in the same cycle as an issue. A design that latched the new length there would break the in-flight guarantee. It probes the boundary lengths 32 and 33, where an off-by-one comparison would flag or miss the error. It sends update masks with bits set above the captured length, which a design that ignored the length would record. It also overlaps a software clear with a hardware update of the same register, where the wrong priority leaves stale sticky bits. It probes holes in the register map such as 3 and 9, where loose decoding would alias them onto real registers.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  localparam int CR_ADDR_W = 5;

  localparam logic [CR_ADDR_W-1:0] CR_REV  = 5'd0;
  localparam logic [CR_ADDR_W-1:0] CR_CNT  = 5'd1;
  localparam logic [CR_ADDR_W-1:0] CR_LEN  = 5'd2;
  localparam logic [CR_ADDR_W-1:0] CR_COND = 5'd4;
  localparam logic [CR_ADDR_W-1:0] CR_OVF  = 5'd8;
  localparam logic [CR_ADDR_W-1:0] CR_SAT  = 5'd12;

  // one-hot hit vector positions
  localparam int HIT_REV  = 0;
  localparam int HIT_CNT  = 1;
  localparam int HIT_LEN  = 2;
  localparam int HIT_FLG0 = 3;   // cond, ovf, sat follow in order
  localparam int NHIT     = 6;
  localparam int NFLAG    = 3;

  typedef enum logic [1:0] {
    UPD_CMP  = 2'd0,
    UPD_OVF  = 2'd1,
    UPD_SAT  = 2'd2,
    UPD_NONE = 2'd3
  } upd_kind_e;
endpackage

// File: rtl/vcr_decode.sv
module vcr_decode
  import vcr_pkg::*;
(
  input  logic [CR_ADDR_W-1:0] addr,
  input  logic                 access,
  output logic [NHIT-1:0]      hit,
  output logic                 illegal
);
  always_comb begin
    hit = '0;
    case (addr)
      CR_REV:  hit[HIT_REV]    = 1'b1;
      CR_CNT:  hit[HIT_CNT]    = 1'b1;
      CR_LEN:  hit[HIT_LEN]    = 1'b1;
      CR_COND: hit[HIT_FLG0]   = 1'b1;
      CR_OVF:  hit[HIT_FLG0+1] = 1'b1;
      CR_SAT:  hit[HIT_FLG0+2] = 1'b1;
      default: hit = '0;
    endcase
    illegal = access && (hit == '0);
  end
endmodule

// File: rtl/vcr_len_unit.sv
module vcr_len_unit #(
  parameter int LEN_W = 8,
  parameter int NELEM = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_wdata,
  input  logic             issue_valid,
  output logic [LEN_W-1:0] len_q,
  output logic [LEN_W-1:0] act_len,
  output logic             act_err,
  output logic [NELEM-1:0] elem_en
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(NELEM);

  // element x takes part when x < n
  function automatic logic [NELEM-1:0] span_mask(input logic [LEN_W-1:0] n);
    span_mask = '0;
    for (int i = 0; i < NELEM; i++)
      span_mask[i] = (int'(n) > i);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      act_len <= '0;
      act_err <= 1'b0;
    end else begin
      if (len_we) len_q <= len_wdata;
      if (issue_valid) begin
        act_len <= len_q;
        act_err <= (len_q > MAX_LEN);
      end
    end
  end

  assign elem_en = span_mask(act_len);
endmodule

// File: rtl/vcr_flag_reg.sv
module vcr_flag_reg #(
  parameter int NELEM  = 32,
  parameter bit STICKY = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [NELEM-1:0] sw_data,
  input  logic             hw_we,
  input  logic [NELEM-1:0] hw_mask,
  input  logic [NELEM-1:0] elem_en,
  output logic [NELEM-1:0] q
);
  logic [NELEM-1:0] hw_next;

  generate
    if (STICKY) begin : g_sticky
      assign hw_next = q | (hw_mask & elem_en);
    end else begin : g_replace
      assign hw_next = (q & ~elem_en) | (hw_mask & elem_en);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (sw_we) q <= sw_data;
    else if (hw_we) q <= hw_next;
  end
endmodule

// File: rtl/vec_ctrl_regs.sv
module vec_ctrl_regs
  import vcr_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          NELEM   = 32,
  parameter int          LEN_W   = 8,
  parameter logic [7:0]  IMP_NUM = 8'h00,
  parameter logic [7:0]  REV_NUM = 8'h03
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    cnt_in,
  input  logic                 cr_rd_en,
  input  logic                 cr_wr_en,
  input  logic [CR_ADDR_W-1:0] cr_addr,
  input  logic [DATA_W-1:0]    cr_wdata,
  output logic [DATA_W-1:0]    cr_rdata,
  output logic                 cr_illegal,
  input  logic                 issue_valid,
  output logic [LEN_W-1:0]     act_len,
  output logic                 act_err,
  input  logic                 upd_valid,
  input  logic [1:0]           upd_kind,
  input  logic [NELEM-1:0]     upd_mask
);
  localparam logic [DATA_W-1:0] REV_WORD = DATA_W'({IMP_NUM, REV_NUM});

  logic [NHIT-1:0]  hit;
  logic [LEN_W-1:0] len_q;
  logic [NELEM-1:0] elem_en;
  logic [NFLAG-1:0] flag_sw_we;
  logic [NFLAG-1:0] flag_hw_we;
  logic [NELEM-1:0] flag_q [NFLAG];
  logic [NELEM-1:0] cond_q, ovf_q, sat_q;

  vcr_decode u_dec (
    .addr    (cr_addr),
    .access  (cr_rd_en | cr_wr_en),
    .hit     (hit),
    .illegal (cr_illegal)
  );

  vcr_len_unit #(.LEN_W(LEN_W), .NELEM(NELEM)) u_len (
    .clk         (clk),
    .rst_n       (rst_n),
    .len_we      (cr_wr_en & hit[HIT_LEN]),
    .len_wdata   (cr_wdata[LEN_W-1:0]),
    .issue_valid (issue_valid),
    .len_q       (len_q),
    .act_len     (act_len),
    .act_err     (act_err),
    .elem_en     (elem_en)
  );

  // flag g sits at hit index HIT_FLG0+g and answers update kind g
  generate
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
      assign flag_sw_we[g] = cr_wr_en & hit[HIT_FLG0+g];
      assign flag_hw_we[g] = upd_valid && (upd_kind == 2'(g));
      vcr_flag_reg #(.NELEM(NELEM), .STICKY(g != 0)) u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_we   (flag_sw_we[g]),
        .sw_data (cr_wdata[NELEM-1:0]),
        .hw_we   (flag_hw_we[g]),
        .hw_mask (upd_mask),
        .elem_en (elem_en),
        .q       (flag_q[g])
      );
    end
  endgenerate

  assign cond_q = flag_q[0];
  assign ovf_q  = flag_q[1];
  assign sat_q  = flag_q[2];

  always_comb begin
    cr_rdata = '0;
    if (hit[HIT_REV])    cr_rdata = REV_WORD;
    if (hit[HIT_CNT])    cr_rdata = cnt_in;
    if (hit[HIT_LEN])    cr_rdata = DATA_W'(len_q);
    if (hit[HIT_FLG0])   cr_rdata = DATA_W'(cond_q);
    if (hit[HIT_FLG0+1]) cr_rdata = DATA_W'(ovf_q);
    if (hit[HIT_FLG0+2]) cr_rdata = DATA_W'(sat_q);
  end
endmodule

// File: rtl/vcr_checker.sv
module vcr_checker #(
  parameter int DATA_W = 32,
  parameter int NELEM  = 32,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cr_rd_en,
  input logic              cr_wr_en,
  input logic [4:0]        cr_addr,
  input logic [DATA_W-1:0] cr_wdata,
  input logic [DATA_W-1:0] cr_rdata,
  input logic              cr_illegal,
  input logic              issue_valid,
  input logic [LEN_W-1:0]  act_len,
  input logic              act_err,
  input logic [LEN_W-1:0]  len_q,
  input logic [NELEM-1:0]  elem_en,
  input logic [2:0]        flag_sw_we,
  input logic [2:0]        flag_hw_we,
  input logic [NELEM-1:0]  cond_q,
  input logic [NELEM-1:0]  ovf_q,
  input logic [NELEM-1:0]  sat_q
);
  p_hole_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cr_rd_en || cr_wr_en) && (cr_addr == 5'd3 || cr_addr == 5'd9)) |-> cr_illegal);

  p_hole_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_rd_en && cr_illegal) |-> (cr_rdata == '0));

  p_rev_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_rd_en && cr_addr == 5'd0) |-> (cr_rdata[DATA_W-1:16] == '0));

  p_issue_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> (act_len == $past(len_q)));

  p_issue_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |=> ($stable(act_len) && $stable(act_err)));

  p_err_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_err == (int'(act_len) > NELEM));

  p_cond_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_sw_we[0] && !flag_hw_we[0]) |=> $stable(cond_q));

  p_cond_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_sw_we[0] |=> ((cond_q & ~$past(elem_en)) == ($past(cond_q) & ~$past(elem_en))));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_sw_we[1] |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));

  p_sat_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_sw_we[2] |=> ((sat_q & $past(sat_q)) == $past(sat_q)));

  p_sw_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_sw_we[1] |=> (ovf_q == $past(cr_wdata[NELEM-1:0])));
endmodule

bind vec_ctrl_regs vcr_checker #(.DATA_W(DATA_W), .NELEM(NELEM), .LEN_W(LEN_W)) u_vcr_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cr_rd_en    (cr_rd_en),
  .cr_wr_en    (cr_wr_en),
  .cr_addr     (cr_addr),
  .cr_wdata    (cr_wdata),
  .cr_rdata    (cr_rdata),
  .cr_illegal  (cr_illegal),
  .issue_valid (issue_valid),
  .act_len     (act_len),
  .act_err     (act_err),
  .len_q       (len_q),
  .elem_en     (elem_en),
  .flag_sw_we  (flag_sw_we),
  .flag_hw_we  (flag_hw_we),
  .cond_q      (cond_q),
  .ovf_q       (ovf_q),
  .sat_q       (sat_q)
);

// File: tb/test_vec_ctrl_regs.sv
module test_vec_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cnt_in = '0;
  logic        cr_rd_en = 1'b0, cr_wr_en = 1'b0;
  logic [4:0]  cr_addr = '0;
  logic [31:0] cr_wdata = '0;
  logic [31:0] cr_rdata;
  logic        cr_illegal;
  logic        issue_valid = 1'b0;
  logic [7:0]  act_len;
  logic        act_err;
  logic        upd_valid = 1'b0;
  logic [1:0]  upd_kind = '0;
  logic [31:0] upd_mask = '0;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vec_ctrl_regs #(.IMP_NUM(8'h00), .REV_NUM(8'h03)) i_vec_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in),
    .cr_rd_en(cr_rd_en), .cr_wr_en(cr_wr_en), .cr_addr(cr_addr),
    .cr_wdata(cr_wdata), .cr_rdata(cr_rdata), .cr_illegal(cr_illegal),
    .issue_valid(issue_valid), .act_len(act_len), .act_err(act_err),
    .upd_valid(upd_valid), .upd_kind(upd_kind), .upd_mask(upd_mask)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // elements below n, restated from the requirement
  function automatic logic [31:0] below(int n);
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  task automatic cr_write(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    cr_wr_en = 1'b1; cr_addr = a; cr_wdata = d;
    @(negedge clk);
    cr_wr_en = 1'b0;
  endtask

  task automatic cr_read(logic [4:0] a, output logic [31:0] d, output logic ill);
    @(negedge clk);
    cr_rd_en = 1'b1; cr_addr = a;
    #1;
    d = cr_rdata; ill = cr_illegal;
    cr_rd_en = 1'b0;
  endtask

  task automatic do_issue();
    @(negedge clk);
    issue_valid = 1'b1;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic do_upd(logic [1:0] k, logic [31:0] m);
    @(negedge clk);
    upd_valid = 1'b1; upd_kind = k; upd_mask = m;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic expect_reg(string req, logic [4:0] a, logic [31:0] exp);
    logic [31:0] d; logic ill;
    cr_read(a, d, ill);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    expect_reg("R1 len", 5'd2, 0);
    expect_reg("R1 cond", 5'd4, 0);
    expect_reg("R1 ovf", 5'd8, 0);
    expect_reg("R1 sat", 5'd12, 0);
    chk("R1 act_len", 32'(act_len), 0);
    chk("R1 act_err", 32'(act_err), 0);
  endtask

  task automatic t_decode();
    logic [31:0] d; logic ill;
    logic [4:0] holes [6] = '{5'd3, 5'd5, 5'd7, 5'd9, 5'd13, 5'd31};
    foreach (holes[i]) begin
      cr_read(holes[i], d, ill);
      chk("R2 illegal flag", 32'(ill), 1);
      chk("R2 illegal data", d, 0);
    end
    cr_read(5'd8, d, ill);
    chk("R2 legal no flag", 32'(ill), 0);
    cr_write(5'd2, 32'h11);
    @(negedge clk);
    cr_wr_en = 1'b1; cr_addr = 5'd6; cr_wdata = 32'hFFFF_FFFF;
    #1 chk("R2 write flag", 32'(cr_illegal), 1);
    @(negedge clk);
    cr_wr_en = 1'b0;
    expect_reg("R2 hole write len", 5'd2, 32'h11);
    expect_reg("R2 hole write cond", 5'd4, 0);
    expect_reg("R2 hole write sat", 5'd12, 0);
  endtask

  task automatic t_readonly();
    expect_reg("R3 rev", 5'd0, 32'h0000_0003);
    cr_write(5'd0, 32'hDEAD_BEEF);
    expect_reg("R3 rev after write", 5'd0, 32'h0000_0003);
    cnt_in = 32'h1234_5678;
    expect_reg("R4 counter", 5'd1, 32'h1234_5678);
    cr_write(5'd1, 32'h0);
    cnt_in = 32'hCAFE_0001;
    expect_reg("R4 counter after write", 5'd1, 32'hCAFE_0001);
  endtask

  task automatic t_length();
    cr_write(5'd2, 32'hFFFF_FF25);
    expect_reg("R5 low byte", 5'd2, 32'h25);
  endtask

  task automatic t_issue();
    cr_write(5'd2, 20); do_issue();
    chk("R6 len20", 32'(act_len), 20); chk("R6 err20", 32'(act_err), 0);
    cr_write(5'd2, 40);
    chk("R6 hold after write", 32'(act_len), 20);
    do_issue();
    chk("R6 len40", 32'(act_len), 40); chk("R6 err40", 32'(act_err), 1);
    cr_write(5'd2, 32); do_issue();
    chk("R6 err at 32", 32'(act_err), 0);
    cr_write(5'd2, 33); do_issue();
    chk("R6 err at 33", 32'(act_err), 1);
    cr_write(5'd2, 10);
    @(negedge clk);
    cr_wr_en = 1'b1; cr_addr = 5'd2; cr_wdata = 5; issue_valid = 1'b1;
    @(negedge clk);
    cr_wr_en = 1'b0; issue_valid = 1'b0;
    chk("R6 same-cycle write", 32'(act_len), 10);
    expect_reg("R6 new len stored", 5'd2, 5);
  endtask

  task automatic t_compare();
    cr_write(5'd2, 8); do_issue();
    cr_write(5'd4, 32'hFFFF_0000);
    do_upd(2'd0, 32'hFFFF_FFA5);
    expect_reg("R7 compare replace", 5'd4,
               (32'hFFFF_0000 & ~below(8)) | (32'hFFFF_FFA5 & below(8)));
    do_upd(2'd0, 32'h0);
    expect_reg("R7 compare clear low", 5'd4, 32'hFFFF_0000);
  endtask

  task automatic t_overflow();
    cr_write(5'd8, 0);
    cr_write(5'd2, 16); do_issue();
    do_upd(2'd1, 32'h0001_0003);
    expect_reg("R8 masked by len", 5'd8, 32'h0000_0003);
    do_upd(2'd1, 32'h0000_0004);
    expect_reg("R8 accumulate", 5'd8, 32'h0000_0007);
    do_upd(2'd1, 32'h0);
    expect_reg("R8 sticky", 5'd8, 32'h0000_0007);
  endtask

  task automatic t_saturate();
    cr_write(5'd12, 0);
    cr_write(5'd2, 32); do_issue();
    do_upd(2'd2, 32'h8000_0001);
    expect_reg("R9 full length", 5'd12, 32'h8000_0001);
    do_upd(2'd2, 32'h0000_0002);
    expect_reg("R9 accumulate", 5'd12, 32'h8000_0003);
    do_upd(2'd2, 32'h0);
    expect_reg("R9 sticky", 5'd12, 32'h8000_0003);
  endtask

  task automatic t_no_effect();
    cr_write(5'd4, 32'h0F0F_0F0F);
    do_upd(2'd3, 32'hFFFF_FFFF);
    expect_reg("R10 kind3 cond", 5'd4, 32'h0F0F_0F0F);
    expect_reg("R10 kind3 ovf", 5'd8, 32'h0000_0007);
    expect_reg("R10 kind3 sat", 5'd12, 32'h8000_0003);
    cr_write(5'd2, 0); do_issue();
    do_upd(2'd0, 32'hFFFF_FFFF);
    do_upd(2'd1, 32'hFFFF_FFFF);
    do_upd(2'd2, 32'hFFFF_FFFF);
    expect_reg("R10 len0 cond", 5'd4, 32'h0F0F_0F0F);
    expect_reg("R10 len0 ovf", 5'd8, 32'h0000_0007);
    expect_reg("R10 len0 sat", 5'd12, 32'h8000_0003);
  endtask

  task automatic t_sw_wins();
    cr_write(5'd2, 32); do_issue();
    @(negedge clk);
    cr_wr_en = 1'b1; cr_addr = 5'd8; cr_wdata = 32'h0000_1000;
    upd_valid = 1'b1; upd_kind = 2'd1; upd_mask = 32'hFFFF_FFFF;
    @(negedge clk);
    cr_wr_en = 1'b0; upd_valid = 1'b0;
    expect_reg("R11 ovf sw wins", 5'd8, 32'h0000_1000);
    @(negedge clk);
    cr_wr_en = 1'b1; cr_addr = 5'd4; cr_wdata = 32'h0000_00F0;
    upd_valid = 1'b1; upd_kind = 2'd0; upd_mask = 32'hFFFF_0000;
    @(negedge clk);
    cr_wr_en = 1'b0; upd_valid = 1'b0;
    expect_reg("R11 cond sw wins", 5'd4, 32'h0000_00F0);
    cr_write(5'd12, 0);
    expect_reg("R11 sat cleared", 5'd12, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_readonly();
    t_length();
    t_issue();
    t_compare();
    t_overflow();
    t_saturate();
    t_no_effect();
    t_sw_wins();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule